// File: doc/BRIEF.md
# Masked Packed Unsigned-to-Double Converter

The block widens packed 32-bit unsigned integers into IEEE-754 double-precision values. One request converts two, four or eight elements, chosen by a vector-length code. Each element is written into its own 64-bit lane of a 512-bit destination. A per-lane mask, together with a merge/zero select, decides whether a lane receives its converted value, keeps what the destination held before, or is cleared. A broadcast flag makes every active lane convert the lowest source element. Destination bits above the chosen length are always cleared.

The request is captured on a valid strobe, and the result appears on the registered outputs one clock later. If the 4-bit register-specifier field is anything other than all ones, the request is rejected. In that case the undefined-opcode flag rises and the destination register keeps its old contents. A rounding-override input exists for encoding compatibility and has no effect, because every 32-bit unsigned value is exact in double precision.

Top module: `cvt_u2d_top`

## Requirements
- R1: Length code 0 selects 2 active lanes (128 bits), code 1 selects 4 lanes (256 bits), and codes 2 and 3 select 8 lanes (512 bits). Lane j reads source bits [32j+31:32j] and writes destination bits [64j+63:64j].
- R2: A converted lane of input 0 is all zeros. A nonzero input with leading-zero count lz gives sign 0 in bit 63, biased exponent 1054-lz in bits [62:52], and a fraction in bits [51:0] holding the bits below the leading one, left-aligned, with zeros underneath.
- R3: When mask enable is low, every active lane is converted, whatever the mask bits are.
- R4: When mask enable is high and the zero select is low, an active lane whose mask bit is 0 takes the value of the matching lane of the previous-destination input.
- R5: When mask enable is high and the zero select is high, an active lane whose mask bit is 0 is written as all zeros.
- R6: Every destination bit from the active length up to bit 511 is zero, whatever the mask, merge and previous-destination inputs are.
- R7: When the broadcast flag is high, every active lane converts source bits [31:0] instead of its own element.
- R8: The rounding-override input has no effect on the result.
- R9: A request whose specifier is not 4'b1111 sets the undefined-opcode flag and leaves the destination output unchanged. An accepted request clears the flag.
- R10: The outputs update one clock after a cycle with the valid strobe high, and the result-valid output is high for exactly that one cycle. Without a strobe, the destination and the flag hold their values.
- R11: After reset, the destination is zero and both the undefined-opcode flag and the result-valid output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_vld | input | 1 | Request strobe |
| i_src | input | 256 | Packed 32-bit unsigned source elements |
| i_len | input | 2 | Vector-length code |
| i_kmask | input | 8 | Per-lane write mask |
| i_kmask_en | input | 1 | Mask enable |
| i_zero | input | 1 | 1: masked-off lanes are zeroed; 0: masked-off lanes merge |
| i_bcast | input | 1 | Broadcast the lowest element to all lanes |
| i_rnd_ovr | input | 3 | Rounding override (ignored) |
| i_dst_prev | input | 512 | Previous destination contents, used for merging |
| i_spec | input | 4 | Register-specifier field; must be 4'b1111 |
| o_vld | output | 1 | Result valid, one cycle after the request |
| o_dst | output | 512 | Registered destination |
| o_ud | output | 1 | Undefined-opcode flag |

## Verification
The hardest case to reach is one where the lane mask, the merge/zero select and the vector length all meet in a single request. An example is a masked-off lane that must merge while the lanes above the active length must still clear, even though the previous-destination input is all ones there. The stimulus forces this by giving every request a previous-destination pattern that differs in each lane, including the inactive ones, so that a lane showing the wrong choice is caught. A rejected specifier is sent right after a request with a known, nonzero result, so that the held destination can be told apart from a freshly computed one.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int ELEM_W   = 32;
  localparam int LANE_W   = 64;
  localparam int MAX_LN   = 8;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int EXP_BIAS = 1023;

  typedef enum logic [1:0] {
    LEN_2  = 2'd0,
    LEN_4  = 2'd1,
    LEN_8  = 2'd2,
    LEN_8B = 2'd3
  } len_code_e;

  function automatic int unsigned lanes_of(input logic [1:0] code);
    case (code)
      LEN_2:   return 2;
      LEN_4:   return 4;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/u2d_lzc.sv
module u2d_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  i_x,
  output logic [CW-1:0] o_cnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    o_cnt = CW'(W);
    for (int b = W - 1; b >= 0; b--) begin
      if (!found && i_x[b]) begin
        o_cnt = CW'(W - 1 - b);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/u2d_lane.sv
module u2d_lane #(
  parameter int IN_W   = cvt_pkg::ELEM_W,
  parameter int OUT_W  = cvt_pkg::LANE_W,
  parameter int EXP_W  = cvt_pkg::EXP_W,
  parameter int FRAC_W = cvt_pkg::FRAC_W,
  parameter int BIAS   = cvt_pkg::EXP_BIAS
) (
  input  logic [IN_W-1:0]  i_elem,
  input  logic [OUT_W-1:0] i_prev,
  input  logic             i_active,
  input  logic             i_write,
  input  logic             i_zero,
  output logic [OUT_W-1:0] o_val
);
  localparam int CW      = $clog2(IN_W) + 1;
  localparam int EXP_TOP = BIAS + IN_W - 1;
  localparam int PAD_W   = FRAC_W - (IN_W - 1);

  logic [CW-1:0]    lz;
  logic [IN_W-1:0]  norm;
  logic [EXP_W-1:0] expo;
  logic [FRAC_W-1:0] frac;
  logic [OUT_W-1:0] conv;

  u2d_lzc #(.W(IN_W), .CW(CW)) u_lzc (.i_x(i_elem), .o_cnt(lz));

  always_comb begin
    norm = i_elem << lz;
    expo = EXP_W'(EXP_TOP) - EXP_W'(lz);
    frac = {norm[IN_W-2:0], {PAD_W{1'b0}}};
    if (i_elem == '0) conv = '0;
    else              conv = {1'b0, expo, frac};
  end

  always_comb begin
    if (!i_active)     o_val = '0;
    else if (i_write)  o_val = conv;
    else if (i_zero)   o_val = '0;
    else               o_val = i_prev;
  end
endmodule

// File: rtl/cvt_u2d_top.sv
module cvt_u2d_top #(
  parameter int ELEM_W = cvt_pkg::ELEM_W,
  parameter int LANE_W = cvt_pkg::LANE_W,
  parameter int MAX_LN = cvt_pkg::MAX_LN,
  parameter int SPEC_W = 4,
  parameter int RND_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      i_vld,
  input  logic [ELEM_W*MAX_LN-1:0]  i_src,
  input  logic [1:0]                i_len,
  input  logic [MAX_LN-1:0]         i_kmask,
  input  logic                      i_kmask_en,
  input  logic                      i_zero,
  input  logic                      i_bcast,
  input  logic [RND_W-1:0]          i_rnd_ovr,
  input  logic [LANE_W*MAX_LN-1:0]  i_dst_prev,
  input  logic [SPEC_W-1:0]         i_spec,
  output logic                      o_vld,
  output logic [LANE_W*MAX_LN-1:0]  o_dst,
  output logic                      o_ud
);
  localparam int DST_W = LANE_W * MAX_LN;

  logic [DST_W-1:0] nxt_dst;
  logic             spec_ok;
  int unsigned      n_lanes;
  logic             rnd_unused;

  assign rnd_unused = ^i_rnd_ovr;
  assign spec_ok    = (i_spec == {SPEC_W{1'b1}});
  assign n_lanes    = cvt_pkg::lanes_of(i_len);

  for (genvar j = 0; j < MAX_LN; j++) begin : g_lane
    logic [ELEM_W-1:0] elem;
    logic              act;
    logic              wr;
    assign elem = i_bcast ? i_src[ELEM_W-1:0] : i_src[j*ELEM_W +: ELEM_W];
    assign act  = (j < n_lanes);
    assign wr   = !i_kmask_en || i_kmask[j];
    u2d_lane #(.IN_W(ELEM_W), .OUT_W(LANE_W)) u_lane (
      .i_elem  (elem),
      .i_prev  (i_dst_prev[j*LANE_W +: LANE_W]),
      .i_active(act),
      .i_write (wr),
      .i_zero  (i_zero),
      .o_val   (nxt_dst[j*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_ud  <= 1'b0;
      o_dst <= '0;
    end else begin
      o_vld <= i_vld;
      if (i_vld) begin
        if (spec_ok) begin
          o_dst <= nxt_dst;
          o_ud  <= 1'b0;
        end else begin
          o_ud  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cvt_u2d_chk.sv
module cvt_u2d_chk (
  input logic         clk,
  input logic         rst,
  input logic         i_vld,
  input logic [1:0]   i_len,
  input logic [7:0]   i_kmask,
  input logic         i_kmask_en,
  input logic         i_zero,
  input logic [511:0] i_dst_prev,
  input logic [3:0]   i_spec,
  input logic         o_vld,
  input logic [511:0] o_dst,
  input logic         o_ud
);
  a_r9_reject_holds: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_spec != 4'hF) |=> (o_ud && $stable(o_dst)));

  a_r9_accept_clears: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_spec == 4'hF) |=> !o_ud);

  a_r6_upper_128: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_spec == 4'hF && i_len == 2'd0) |=> (o_dst[511:128] == '0));

  a_r6_upper_256: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_spec == 4'hF && i_len == 2'd1) |=> (o_dst[511:256] == '0));

  a_r5_zero_lane0: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_spec == 4'hF && i_kmask_en && !i_kmask[0] && i_zero)
    |=> (o_dst[63:0] == '0));

  a_r4_merge_lane0: assert property (@(posedge clk) disable iff (rst)
    (i_vld && i_spec == 4'hF && i_kmask_en && !i_kmask[0] && !i_zero)
    |=> (o_dst[63:0] == $past(i_dst_prev[63:0])));

  a_r10_vld_pulse: assert property (@(posedge clk) disable iff (rst)
    i_vld |=> o_vld);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !i_vld |=> (!o_vld && $stable(o_dst) && $stable(o_ud)));
endmodule

bind cvt_u2d_top cvt_u2d_chk u_chk (
  .clk(clk), .rst(rst), .i_vld(i_vld), .i_len(i_len), .i_kmask(i_kmask),
  .i_kmask_en(i_kmask_en), .i_zero(i_zero), .i_dst_prev(i_dst_prev),
  .i_spec(i_spec), .o_vld(o_vld), .o_dst(o_dst), .o_ud(o_ud)
);

// File: tb/test_cvt_u2d_top.sv
module test_cvt_u2d_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         i_vld = 1'b0;
  logic [255:0] i_src = '0;
  logic [1:0]   i_len = '0;
  logic [7:0]   i_kmask = '0;
  logic         i_kmask_en = 1'b0;
  logic         i_zero = 1'b0;
  logic         i_bcast = 1'b0;
  logic [2:0]   i_rnd_ovr = '0;
  logic [511:0] i_dst_prev = '0;
  logic [3:0]   i_spec = 4'hF;
  logic         o_vld;
  logic [511:0] o_dst;
  logic         o_ud;

  int n_chk = 0;
  int n_fail = 0;
  logic [511:0] model_dst = '0;
  logic [511:0] q_dst[$];
  logic         q_ud[$];
  string        q_tag[$];

  always #2 clk = ~clk;

  cvt_u2d_top i_cvt_u2d_top (
    .clk(clk), .rst(rst), .i_vld(i_vld), .i_src(i_src), .i_len(i_len),
    .i_kmask(i_kmask), .i_kmask_en(i_kmask_en), .i_zero(i_zero),
    .i_bcast(i_bcast), .i_rnd_ovr(i_rnd_ovr), .i_dst_prev(i_dst_prev),
    .i_spec(i_spec), .o_vld(o_vld), .o_dst(o_dst), .o_ud(o_ud)
  );

  function automatic logic [63:0] ref_cvt(input logic [31:0] x);
    real r;
    r = real'(longint'({32'h0, x}));
    return $realtobits(r);
  endfunction

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] len, input logic [255:0] src,
                       input logic [7:0] km, input logic kme, input logic zr,
                       input logic bc, input logic [2:0] rnd,
                       input logic [511:0] prev, input logic [3:0] spec,
                       input string tag);
    int lanes;
    logic [511:0] e;
    @(negedge clk);
    i_len = len; i_src = src; i_kmask = km; i_kmask_en = kme; i_zero = zr;
    i_bcast = bc; i_rnd_ovr = rnd; i_dst_prev = prev; i_spec = spec; i_vld = 1'b1;
    lanes = (len == 2'd0) ? 2 : (len == 2'd1) ? 4 : 8;
    e = '0;
    for (int j = 0; j < 8; j++) begin
      if (j < lanes) begin
        if (!kme || km[j]) e[j*64 +: 64] = ref_cvt(bc ? src[31:0] : src[j*32 +: 32]);
        else if (!zr)      e[j*64 +: 64] = prev[j*64 +: 64];
      end
    end
    if (spec == 4'hF) begin
      model_dst = e;
      q_ud.push_back(1'b0);
    end else begin
      q_ud.push_back(1'b1);
    end
    q_dst.push_back(model_dst);
    q_tag.push_back(tag);
    @(negedge clk);
    i_vld = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && o_vld) begin
      if (q_dst.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: unexpected result, actual o_vld=1 expected 0");
      end else begin
        string t;
        logic [511:0] ed;
        logic eu;
        t = q_tag.pop_front();
        ed = q_dst.pop_front();
        eu = q_ud.pop_front();
        check(t, o_dst, ed);
        check({t, " flag R9"}, {511'b0, o_ud}, {511'b0, eu});
      end
    end
  end

  function automatic logic [255:0] pat(input int seed);
    logic [255:0] v;
    logic [31:0] s;
    s = 32'(seed) * 32'h9E3779B9 + 32'h1234567;
    for (int j = 0; j < 8; j++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      v[j*32 +: 32] = s >> (j * 3);
    end
    return v;
  endfunction

  function automatic logic [511:0] prevpat(input int seed);
    logic [511:0] v;
    for (int j = 0; j < 8; j++) v[j*64 +: 64] = {32'hA5A50000 + 32'(j + seed), 32'hDEAD0000 + 32'(j)};
    return v;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [255:0] s;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 reset dst", o_dst, '0);
    check("R11 reset flags", {510'b0, o_ud, o_vld}, '0);

    // R1 R2: 128-bit, inputs 0 and 1
    drive(2'd0, {192'h0, 32'h1, 32'h0}, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, '1, 4'hF, "R1 R2 R6 len128 zero/one");
    // R2: all ones and top-bit values, 256-bit
    drive(2'd1, {128'h0, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00010000}, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, prevpat(1), 4'hF, "R1 R2 len256");
    // R3: mask disabled with mask bits all zero, 512-bit
    drive(2'd2, pat(3), 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, prevpat(2), 4'hF, "R3 mask off len512");
    // R4 merging
    drive(2'd1, pat(4), 8'b0101, 1'b1, 1'b0, 1'b0, 3'd0, prevpat(3), 4'hF, "R4 merge len256");
    drive(2'd2, pat(5), 8'b1001_0110, 1'b1, 1'b0, 1'b0, 3'd0, prevpat(4), 4'hF, "R4 merge len512");
    // R5 zeroing
    drive(2'd1, pat(6), 8'b1010, 1'b1, 1'b1, 1'b0, 3'd0, prevpat(5), 4'hF, "R5 zero len256");
    drive(2'd2, pat(7), 8'b0110_1001, 1'b1, 1'b1, 1'b0, 3'd0, prevpat(6), 4'hF, "R5 zero len512");
    // R6 upper clear with merge and all-ones previous
    drive(2'd0, pat(8), 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, '1, 4'hF, "R6 upper clear merge");
    // R7 broadcast
    s = pat(9); s[31:0] = 32'hFFFFFFFF;
    drive(2'd2, s, 8'hFF, 1'b0, 1'b0, 1'b1, 3'd0, prevpat(7), 4'hF, "R7 bcast len512");
    drive(2'd1, pat(10), 8'b0011, 1'b1, 1'b1, 1'b1, 3'd0, prevpat(8), 4'hF, "R7 bcast masked");
    // R8 rounding override ignored: same as previous with different override
    drive(2'd1, pat(10), 8'b0011, 1'b1, 1'b1, 1'b1, 3'd5, prevpat(8), 4'hF, "R8 rnd ignored");
    drive(2'd2, pat(11), 8'h5A, 1'b1, 1'b0, 1'b0, 3'd7, prevpat(9), 4'hF, "R8 rnd ignored b");
    // R1 length code 3
    drive(2'd3, pat(12), 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, prevpat(10), 4'hF, "R1 len code3");
    // R9 rejected specifiers
    drive(2'd0, pat(13), 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, '0, 4'h7, "R9 reject 0111");
    drive(2'd2, pat(14), 8'hFF, 1'b0, 1'b0, 1'b0, 3'd0, '0, 4'h0, "R9 reject 0000");
    drive(2'd0, pat(15), 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, '0, 4'hF, "R9 accept clears");
    // R10 hold without strobe
    i_src = pat(99); i_dst_prev = '1; i_len = 2'd2;
    repeat (3) @(negedge clk);
    check("R10 hold dst", o_dst, model_dst);
    check("R10 no vld", {511'b0, o_vld}, '0);
    // mixed patterns
    for (int k = 0; k < 24; k++)
      drive(2'(k % 4), pat(100 + k), 8'(k * 37), k[0], k[1], k[2] & k[3], 3'(k), prevpat(k), 4'hF, "R2 R3 R4 R5 mixed");
    repeat (4) @(negedge clk);
    if (q_dst.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10: actual %0d pending results expected 0", q_dst.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule